// File: doc/BRIEF.md
# Bus Slave Burst Command Generator

This block is the slave-side front end of a bridge between an AHB bus and a memory-controller request pipe. It watches the address phase of every transfer aimed at it and sorts each one by transfer type. For every accepted read or write burst it writes a compact command (direction, burst kind, size and beat count) into a command queue and the burst start address into an address queue. Write beats carry their data into a write-data queue. Read beats are answered from a read-data queue that the pipe side fills.

The block drives the bus ready and response signals itself. It stretches a data phase with wait states while a queue it must write is full, and while a read beat has no data yet. A beat counter and a next-address tracker follow every burst. For wrapping bursts the tracker wraps at a boundary equal to the beat size times the beat count. A burst of undefined length is split into one single-beat command per beat. A request wider than the 32-bit data bus gets the two-cycle error response.

Top module: `ahbs_cmdgen`

## Requirements
- R1: After reset the ready output is high, the response is OKAY (00) and the command, address and write-data queues all show empty.
- R2: A beat with transfer type IDLE (00) or BUSY (01), or any beat with select low, is answered with ready high and OKAY in its data phase and writes no queue.
- R3: A NONSEQ (10) beat with a size code of 0, 1 or 2 pushes one command {write, burst code, size code, beat count} and its address. The beat count is 1 for SINGLE (000), 4 for codes 010/011, 8 for 100/101 and 16 for 110/111. The SEQ (11) beats of such a fixed-length burst push no command.
- R4: For the undefined-length INCR burst (code 001), every beat, NONSEQ or SEQ, pushes its own command with burst code 001 and beat count 1.
- R5: The write data of each write beat enters the write-data queue in the data-phase cycle in which ready is high, one entry per beat, in bus order.
- R6: A read data phase keeps ready low with OKAY while the read-data queue is empty. In the first cycle where that queue holds data, ready goes high, the read-data output shows the queue head, and that entry is removed.
- R7: A data phase that must push a command while the command or address queue is full, or write data while the write-data queue is full, holds ready low with OKAY until space appears.
- R8: A NONSEQ or SEQ beat with a size code above 2 gets ERROR (01) with ready low for one cycle, then ERROR with ready high. It pushes nothing.
- R9: A SEQ beat carries the previous beat address plus the size in bytes. Wrapping bursts (codes 010, 100, 110) wrap inside a boundary of size times beat count. Each INCR command takes the tracked address of its beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| hsel_i | input | 1 | Slave select |
| haddr_i | input | ADDR_W | Transfer address |
| htrans_i | input | 2 | Transfer type |
| hwrite_i | input | 1 | 1 write, 0 read |
| hsize_i | input | 3 | Transfer size code |
| hburst_i | input | 3 | Burst code |
| hwdata_i | input | DATA_W | Write data |
| hready_o | output | 1 | Transfer done / wait state |
| hresp_o | output | 2 | 00 OKAY, 01 ERROR |
| hrdata_o | output | DATA_W | Read data |
| cmd_valid_o | output | 1 | Command queue not empty |
| cmd_write_o | output | 1 | Command direction |
| cmd_burst_o | output | 3 | Command burst code |
| cmd_size_o | output | 3 | Command size code |
| cmd_beats_o | output | 5 | Command beat count |
| cmd_pop_i | input | 1 | Remove head command |
| adr_valid_o | output | 1 | Address queue not empty |
| adr_o | output | ADDR_W | Head start address |
| adr_pop_i | input | 1 | Remove head address |
| wdq_valid_o | output | 1 | Write-data queue not empty |
| wdq_data_o | output | DATA_W | Head write data |
| wdq_pop_i | input | 1 | Remove head write data |
| rdq_push_i | input | 1 | Add read data |
| rdq_data_i | input | DATA_W | Read data from the pipe side |
| rdq_full_o | output | 1 | Read-data queue full |

## Verification
An address phase is registered at the edge that accepts it. Its response and ready are visible from the following cycle. A command and address pushed in a data phase appear on the queue outputs one edge after that data phase starts. Write data appears one edge after the completing cycle. Read data and ready respond combinationally to the read queue, one edge after the pipe side pushes into it. The bench drives every input on the falling edge and samples on the falling edge. Before each check it waits out the exact number of rising edges: one after acceptance for the response, one more for queue contents, and two cycles for the error pair.

// File: rtl/ahbs_cmd_pkg.sv
package ahbs_cmd_pkg;

    localparam logic [1:0] TR_IDLE = 2'b00;
    localparam logic [1:0] TR_BUSY = 2'b01;
    localparam logic [1:0] TR_NSEQ = 2'b10;
    localparam logic [1:0] TR_SEQ  = 2'b11;

    localparam logic [2:0] BU_SINGLE = 3'b000;
    localparam logic [2:0] BU_INCR   = 3'b001;

    localparam logic [1:0] RSP_OKAY = 2'b00;
    localparam logic [1:0] RSP_ERR  = 2'b01;

    localparam logic [2:0] SIZE_MAX = 3'd2;

    typedef struct packed {
        logic       write;
        logic [2:0] burst;
        logic [2:0] size;
        logic [4:0] beats;
    } cmd_t;

    // beats per burst code; undefined-length bursts are split into single beats
    function automatic logic [4:0] beats_of(input logic [2:0] burst);
        if (burst[2:1] == 2'b00) return 5'd1;
        return 5'd1 << ({1'b0, burst[2:1]} + 3'd1);
    endfunction

    function automatic logic is_wrap(input logic [2:0] burst);
        return (burst[0] == 1'b0) && (burst[2:1] != 2'b00);
    endfunction

endpackage

// File: rtl/ahbs_fifo.sv
module ahbs_fifo
    import ahbs_cmd_pkg::*;
#(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push_i,
    input  logic [W-1:0] din_i,
    input  logic         pop_i,
    output logic [W-1:0] dout_o,
    output logic         empty_o,
    output logic         full_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = PW + 1;

    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t         ptr_d, ptr_q;
    logic [W-1:0] mem_q [DEPTH];
    logic         push_ok, pop_ok;

    assign empty_o = (ptr_q.cnt == '0);
    assign full_o  = (ptr_q.cnt == CW'(DEPTH));
    assign push_ok = push_i && !full_o;
    assign pop_ok  = pop_i && !empty_o;
    assign dout_o  = mem_q[ptr_q.rp];

    always_comb begin
        ptr_d = ptr_q;
        if (push_ok) ptr_d.wp = ptr_q.wp + PW'(1);
        if (pop_ok)  ptr_d.rp = ptr_q.rp + PW'(1);
        ptr_d.cnt = ptr_q.cnt + CW'(push_ok) - CW'(pop_ok);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem_q[ptr_q.wp] <= din_i;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !full_o); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o); // R6

endmodule

// File: rtl/ahbs_burst_track.sv
module ahbs_burst_track
    import ahbs_cmd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic [1:0]        trans_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [2:0]        size_i,
    input  logic [2:0]        burst_i,
    output logic [ADDR_W-1:0] exp_addr_o
);
    typedef struct packed {
        logic [ADDR_W-1:0] nxt;
        logic [4:0]        left;
    } trk_t;

    trk_t trk_d, trk_q;

    function automatic logic [ADDR_W-1:0] step(input logic [ADDR_W-1:0] a,
                                               input logic [2:0] sz,
                                               input logic [2:0] bu);
        logic [ADDR_W-1:0] bytes, inc, span, mask;
        bytes = ADDR_W'(1) << sz;
        inc   = a + bytes;
        span  = bytes << ({1'b0, bu[2:1]} + 3'd1);
        mask  = span - ADDR_W'(1);
        if (is_wrap(bu)) return (a & ~mask) | (inc & mask);
        return inc;
    endfunction

    assign exp_addr_o = trk_q.nxt;

    always_comb begin
        trk_d = trk_q;
        if (acc_i) begin
            trk_d.nxt = step(addr_i, size_i, burst_i);
            if (trans_i == TR_NSEQ)
                trk_d.left = beats_of(burst_i) - 5'd1;
            else if (burst_i != BU_INCR)
                trk_d.left = trk_q.left - 5'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    AST_SEQ_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        acc_i && (trans_i == TR_SEQ) |-> addr_i == trk_q.nxt); // R9
    AST_BEAT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        acc_i && (trans_i == TR_SEQ) && (burst_i != BU_INCR) |-> trk_q.left != 5'd0); // R3

endmodule

// File: rtl/ahbs_cmdgen.sv
module ahbs_cmdgen
    import ahbs_cmd_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CMD_DEPTH = 4,
    parameter int DAT_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel_i,
    input  logic [ADDR_W-1:0] haddr_i,
    input  logic [1:0]        htrans_i,
    input  logic              hwrite_i,
    input  logic [2:0]        hsize_i,
    input  logic [2:0]        hburst_i,
    input  logic [DATA_W-1:0] hwdata_i,
    output logic              hready_o,
    output logic [1:0]        hresp_o,
    output logic [DATA_W-1:0] hrdata_o,
    output logic              cmd_valid_o,
    output logic              cmd_write_o,
    output logic [2:0]        cmd_burst_o,
    output logic [2:0]        cmd_size_o,
    output logic [4:0]        cmd_beats_o,
    input  logic              cmd_pop_i,
    output logic              adr_valid_o,
    output logic [ADDR_W-1:0] adr_o,
    input  logic              adr_pop_i,
    output logic              wdq_valid_o,
    output logic [DATA_W-1:0] wdq_data_o,
    input  logic              wdq_pop_i,
    input  logic              rdq_push_i,
    input  logic [DATA_W-1:0] rdq_data_i,
    output logic              rdq_full_o
);
    localparam int CMD_W = $bits(cmd_t);

    typedef struct packed {
        logic              valid;
        logic              write;
        logic              err;
        logic              need_cmd;
        logic [2:0]        burst;
        logic [2:0]        size;
        logic [ADDR_W-1:0] addr;
    } dphase_t;

    typedef struct packed {
        dphase_t dp;
        logic    cmd_done;
        logic    err2;
    } state_t;

    state_t            st_d, st_q;
    logic              acc, cmd_push, wf_push, rf_pop;
    logic              cmd_full, cmd_empty, adr_full, adr_empty;
    logic              wf_full, wf_empty, rf_empty;
    logic              cmd_ok;
    logic [ADDR_W-1:0] exp_addr;
    cmd_t              cmd_in, cmd_out;

    assign acc = hsel_i && hready_o && htrans_i[1];

    ahbs_burst_track #(.ADDR_W(ADDR_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_i     (acc),
        .trans_i   (htrans_i),
        .addr_i    (haddr_i),
        .size_i    (hsize_i),
        .burst_i   (hburst_i),
        .exp_addr_o(exp_addr)
    );

    // data-phase handshake
    always_comb begin
        cmd_ok   = !st_q.dp.need_cmd || st_q.cmd_done || (!cmd_full && !adr_full);
        cmd_push = st_q.dp.valid && !st_q.dp.err && st_q.dp.need_cmd && !st_q.cmd_done
                   && !cmd_full && !adr_full;
        if (!st_q.dp.valid)
            hready_o = 1'b1;
        else if (st_q.dp.err)
            hready_o = st_q.err2;
        else if (st_q.dp.write)
            hready_o = cmd_ok && !wf_full;
        else
            hready_o = cmd_ok && !rf_empty;
        hresp_o = (st_q.dp.valid && st_q.dp.err) ? RSP_ERR : RSP_OKAY;
        wf_push = st_q.dp.valid && !st_q.dp.err && st_q.dp.write && hready_o;
        rf_pop  = st_q.dp.valid && !st_q.dp.err && !st_q.dp.write && hready_o;
    end

    always_comb begin
        cmd_in.write = st_q.dp.write;
        cmd_in.burst = st_q.dp.burst;
        cmd_in.size  = st_q.dp.size;
        cmd_in.beats = (st_q.dp.burst == BU_INCR) ? 5'd1 : beats_of(st_q.dp.burst);
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (hready_o) begin
            st_d.cmd_done    = 1'b0;
            st_d.err2        = 1'b0;
            st_d.dp.valid    = acc;
            st_d.dp.write    = hwrite_i;
            st_d.dp.err      = acc && (hsize_i > SIZE_MAX);
            st_d.dp.need_cmd = (htrans_i == TR_NSEQ) || (hburst_i == BU_INCR);
            st_d.dp.burst    = hburst_i;
            st_d.dp.size     = hsize_i;
            st_d.dp.addr     = (htrans_i == TR_NSEQ) ? haddr_i : exp_addr;
        end else begin
            if (cmd_push) st_d.cmd_done = 1'b1;
            if (st_q.dp.err) st_d.err2 = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    ahbs_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
        .clk(clk), .rst_n(rst_n),
        .push_i(cmd_push), .din_i(cmd_in),
        .pop_i(cmd_pop_i), .dout_o(cmd_out),
        .empty_o(cmd_empty), .full_o(cmd_full)
    );

    ahbs_fifo #(.W(ADDR_W), .DEPTH(CMD_DEPTH)) u_adr_q (
        .clk(clk), .rst_n(rst_n),
        .push_i(cmd_push), .din_i(st_q.dp.addr),
        .pop_i(adr_pop_i), .dout_o(adr_o),
        .empty_o(adr_empty), .full_o(adr_full)
    );

    ahbs_fifo #(.W(DATA_W), .DEPTH(DAT_DEPTH)) u_wdat_q (
        .clk(clk), .rst_n(rst_n),
        .push_i(wf_push), .din_i(hwdata_i),
        .pop_i(wdq_pop_i), .dout_o(wdq_data_o),
        .empty_o(wf_empty), .full_o(wf_full)
    );

    ahbs_fifo #(.W(DATA_W), .DEPTH(DAT_DEPTH)) u_rdat_q (
        .clk(clk), .rst_n(rst_n),
        .push_i(rdq_push_i), .din_i(rdq_data_i),
        .pop_i(rf_pop), .dout_o(hrdata_o),
        .empty_o(rf_empty), .full_o(rdq_full_o)
    );

    assign cmd_valid_o = !cmd_empty;
    assign cmd_write_o = cmd_out.write;
    assign cmd_burst_o = cmd_out.burst;
    assign cmd_size_o  = cmd_out.size;
    assign cmd_beats_o = cmd_out.beats;
    assign adr_valid_o = !adr_empty;
    assign wdq_valid_o = !wf_empty;

    AST_IDLE_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        hsel_i && hready_o && !htrans_i[1] |=> hready_o && hresp_o == RSP_OKAY); // R2
    AST_ERR_SECOND: assert property (@(posedge clk) disable iff (!rst_n)
        (hresp_o == RSP_ERR) && !hready_o |=> (hresp_o == RSP_ERR) && hready_o); // R8
    AST_ERR_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        hresp_o == RSP_ERR |-> !cmd_push && !wf_push); // R8
    AST_WAIT_OKAY: assert property (@(posedge clk) disable iff (!rst_n)
        !hready_o && !st_q.dp.err |-> hresp_o == RSP_OKAY); // R7
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.dp.valid && !st_q.dp.write && !st_q.dp.err && rf_empty |-> !hready_o); // R6
    AST_ONE_CMD_PER_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_push && !hready_o |=> !cmd_push); // R3

endmodule

// File: tb/ahbs_cmdgen_tb.sv
module ahbs_cmdgen_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;
    // {address, size code, write data}
    localparam logic [66:0] VECS [NV] = '{
        {32'h0000_1001, 3'd0, 32'h0000_005A},
        {32'h0000_2002, 3'd1, 32'h0000_BEEF},
        {32'h0000_3000, 3'd2, 32'hDEAD_0001},
        {32'h0000_0003, 3'd0, 32'h0000_00C3},
        {32'h0000_FFFC, 3'd2, 32'h1234_5678},
        {32'h0000_0010, 3'd1, 32'h0000_7E7E}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hsel = 1'b0, hwrite = 1'b0;
    logic [31:0] haddr = '0, hwdata = '0;
    logic [1:0]  htrans = 2'b00;
    logic [2:0]  hsize = 3'd2, hburst = 3'd0;
    logic        hready;
    logic [1:0]  hresp;
    logic [31:0] hrdata;
    logic        cmd_valid, cmd_write, cmd_pop = 1'b0;
    logic [2:0]  cmd_burst, cmd_size;
    logic [4:0]  cmd_beats;
    logic        adr_valid, adr_pop = 1'b0;
    logic [31:0] adr;
    logic        wdq_valid, wdq_pop = 1'b0;
    logic [31:0] wdq_data;
    logic        rdq_push = 1'b0, rdq_full;
    logic [31:0] rdq_data = '0;

    int nchk = 0, nfail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ahbs_cmdgen u_dut (
        .clk(clk), .rst_n(rst_n), .hsel_i(hsel), .haddr_i(haddr),
        .htrans_i(htrans), .hwrite_i(hwrite), .hsize_i(hsize), .hburst_i(hburst),
        .hwdata_i(hwdata), .hready_o(hready), .hresp_o(hresp), .hrdata_o(hrdata),
        .cmd_valid_o(cmd_valid), .cmd_write_o(cmd_write), .cmd_burst_o(cmd_burst),
        .cmd_size_o(cmd_size), .cmd_beats_o(cmd_beats), .cmd_pop_i(cmd_pop),
        .adr_valid_o(adr_valid), .adr_o(adr), .adr_pop_i(adr_pop),
        .wdq_valid_o(wdq_valid), .wdq_data_o(wdq_data), .wdq_pop_i(wdq_pop),
        .rdq_push_i(rdq_push), .rdq_data_i(rdq_data), .rdq_full_o(rdq_full)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] cmdw(input logic w, input logic [2:0] b,
                                         input logic [2:0] s, input logic [4:0] n);
        return {20'd0, w, b, s, n};
    endfunction

    // caller is at a falling edge; returns at the falling edge after acceptance
    task automatic addr_beat(input logic [1:0] tr, input logic wr, input logic [31:0] a,
                             input logic [2:0] sz, input logic [2:0] bu);
        hsel = 1'b1; htrans = tr; hwrite = wr; haddr = a; hsize = sz; hburst = bu;
        while (hready !== 1'b1) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic go_idle();
        hsel = 1'b0; htrans = 2'b00;
    endtask

    task automatic data_end(output logic [1:0] r);
        while (hready !== 1'b1) @(negedge clk);
        r = hresp;
        @(negedge clk);
    endtask

    task automatic single_write(input logic [31:0] a, input logic [2:0] sz,
                                input logic [31:0] d, output logic [1:0] r);
        addr_beat(2'b10, 1'b1, a, sz, 3'b000);
        hwdata = d;
        go_idle();
        data_end(r);
    endtask

    task automatic pop_all(output logic [31:0] c, output logic [31:0] ad,
                           output logic [31:0] wd);
        c  = cmd_valid ? cmdw(cmd_write, cmd_burst, cmd_size, cmd_beats) : 32'hFFFF_FFFF;
        ad = adr_valid ? adr : 32'hFFFF_FFFF;
        wd = wdq_valid ? wdq_data : 32'hFFFF_FFFF;
        cmd_pop = cmd_valid; adr_pop = adr_valid; wdq_pop = wdq_valid;
        @(negedge clk);
        cmd_pop = 1'b0; adr_pop = 1'b0; wdq_pop = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk++; nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [1:0]  r;
        logic [31:0] c, ad, wd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 ready", {31'd0, hready}, 32'd1);
        chk("R1 resp", {30'd0, hresp}, 32'd0);
        chk("R1 queues empty", {29'd0, cmd_valid, adr_valid, wdq_valid}, 32'd0);

        // R2 BUSY beat, then unselected NONSEQ
        hsel = 1'b1; htrans = 2'b01; hwrite = 1'b1; haddr = 32'h80;
        @(negedge clk);
        chk("R2 busy ready/resp", {29'd0, hready, hresp}, 32'h4);
        hsel = 1'b0; htrans = 2'b10;
        @(negedge clk);
        chk("R2 unselected ready/resp", {29'd0, hready, hresp}, 32'h4);
        go_idle();
        @(negedge clk);
        chk("R2 no entries", {29'd0, cmd_valid, adr_valid, wdq_valid}, 32'd0);

        // table of single writes: R3 command, R5 data
        for (int i = 0; i < NV; i++) begin
            single_write(VECS[i][66:35], VECS[i][34:32], VECS[i][31:0], r);
            chk("R3 single resp", {30'd0, r}, 32'd0);
            pop_all(c, ad, wd);
            chk("R3 single cmd", c, cmdw(1'b1, 3'b000, VECS[i][34:32], 5'd1));
            chk("R3 single addr", ad, VECS[i][66:35]);
            chk("R5 single wdata", wd, VECS[i][31:0]);
        end

        // R6 read waits for read data
        addr_beat(2'b10, 1'b0, 32'h40, 3'd2, 3'b000);
        go_idle();
        chk("R6 wait ready low", {31'd0, hready}, 32'd0);
        chk("R6 wait resp okay", {30'd0, hresp}, 32'd0);
        @(negedge clk);
        chk("R6 cmd pushed before data", {31'd0, cmd_valid}, 32'd1);
        chk("R6 still waiting", {31'd0, hready}, 32'd0);
        rdq_push = 1'b1; rdq_data = 32'hA5A5_1234;
        @(negedge clk);
        rdq_push = 1'b0;
        chk("R6 ready with data", {31'd0, hready}, 32'd1);
        chk("R6 read data", hrdata, 32'hA5A5_1234);
        @(negedge clk);
        pop_all(c, ad, wd);
        chk("R3 read cmd", c, cmdw(1'b0, 3'b000, 3'd2, 5'd1));
        chk("R3 read addr", ad, 32'h40);

        // R3/R9 wrap4 word burst from 0x34
        addr_beat(2'b10, 1'b1, 32'h34, 3'd2, 3'b010);
        hwdata = 32'hD0;
        addr_beat(2'b11, 1'b1, 32'h38, 3'd2, 3'b010);
        hwdata = 32'hD1;
        addr_beat(2'b11, 1'b1, 32'h3C, 3'd2, 3'b010);
        hwdata = 32'hD2;
        addr_beat(2'b11, 1'b1, 32'h30, 3'd2, 3'b010);
        hwdata = 32'hD3;
        go_idle();
        data_end(r);
        pop_all(c, ad, wd);
        chk("R3 wrap4 cmd", c, cmdw(1'b1, 3'b010, 3'd2, 5'd4));
        chk("R3 wrap4 addr", ad, 32'h34);
        chk("R5 wrap4 data0", wd, 32'hD0);
        chk("R3 wrap4 single command", {31'd0, cmd_valid}, 32'd0);
        for (int k = 1; k < 4; k++) begin
            pop_all(c, ad, wd);
            chk("R5 wrap4 data order", wd, 32'hD0 + 32'(k));
        end

        // R4/R9 undefined-length burst: one command per beat
        addr_beat(2'b10, 1'b1, 32'h100, 3'd2, 3'b001);
        hwdata = 32'hE0;
        addr_beat(2'b11, 1'b1, 32'h104, 3'd2, 3'b001);
        hwdata = 32'hE1;
        addr_beat(2'b11, 1'b1, 32'h108, 3'd2, 3'b001);
        hwdata = 32'hE2;
        go_idle();
        data_end(r);
        for (int k = 0; k < 3; k++) begin
            pop_all(c, ad, wd);
            chk("R4 incr cmd", c, cmdw(1'b1, 3'b001, 3'd2, 5'd1));
            chk("R9 incr beat addr", ad, 32'h100 + 32'(4 * k));
            chk("R5 incr data", wd, 32'hE0 + 32'(k));
        end

        // R8 oversize request
        addr_beat(2'b10, 1'b1, 32'h200, 3'd3, 3'b000);
        hwdata = 32'h99;
        go_idle();
        chk("R8 first cycle", {29'd0, hready, hresp}, 32'h1);
        @(negedge clk);
        chk("R8 second cycle", {29'd0, hready, hresp}, 32'h5);
        @(negedge clk);
        chk("R8 nothing pushed", {29'd0, cmd_valid, adr_valid, wdq_valid}, 32'd0);

        // R7 queues full stall
        for (int k = 0; k < 4; k++) begin
            single_write(32'h300 + 32'(4 * k), 3'd2, 32'h11 * 32'(k + 1), r);
        end
        addr_beat(2'b10, 1'b1, 32'h310, 3'd2, 3'b000);
        hwdata = 32'h55;
        go_idle();
        chk("R7 stall ready low", {31'd0, hready}, 32'd0);
        chk("R7 stall resp okay", {30'd0, hresp}, 32'd0);
        @(negedge clk);
        chk("R7 still stalled", {31'd0, hready}, 32'd0);
        pop_all(c, ad, wd);
        chk("R7 first drained", wd, 32'h11);
        chk("R7 ready after space", {31'd0, hready}, 32'd1);
        data_end(r);
        for (int k = 0; k < 4; k++) pop_all(c, ad, wd);
        chk("R7 stalled write addr", ad, 32'h310);
        chk("R7 stalled write data", wd, 32'h55);
        chk("R7 queues empty", {29'd0, cmd_valid, adr_valid, wdq_valid}, 32'd0);

        finish_run();
    end
endmodule